// File: doc/BRIEF.md
# Melody Note Sequencer and Tone Generator

This block plays tunes held as packed 22-bit note words in a note memory that sits beside it. The host picks a tune number from 1 to 31 and pulses `start`. The sequencer reads the tune's first-note pointer from a table in the low words of the memory. It then fetches note words one after another and decodes each one into a pitch code, a beat length, a tempo multiplier and effect flags. While a note plays, a beat counter times the note, a half-period divider produces the main square wave on `tone_a`, and `tone_b` carries either a second square wave one octave lower or a pseudo-random percussion noise.

The memory is reached through a synchronous read port. The block drives `mem_rd` and `mem_addr` in one cycle, and the word must appear on `mem_rdata` in the next cycle. Busy reporting works in one of two modes, latched at start. In tune mode, `busy` stays high until the note flagged as last has finished. In note mode, `busy` drops after every note, and the sequencer holds until the host pulses `start` again. Every completion pulses `irq` for one cycle. A `stop` pulse ends playback at once from any state.

The controller is a seven-state machine:
- `ST_IDLE`: waits for a start. Goes to `ST_TBL_REQ` on `start` with a non-zero tune number.
- `ST_TBL_REQ`: reads the table entry. Always goes to `ST_TBL_CAP`.
- `ST_TBL_CAP`: captures the pointer. Always goes to `ST_NOTE_REQ`.
- `ST_NOTE_REQ`: reads the note word. Always goes to `ST_NOTE_CAP`.
- `ST_NOTE_CAP`: latches the note and loads the counters. Always goes to `ST_PLAY`.
- `ST_PLAY`: plays the note. In its last cycle it goes to `ST_IDLE` if the note is the last of the tune, to `ST_WAIT` in note mode, and to `ST_NOTE_REQ` otherwise.
- `ST_WAIT`: holds between notes in note mode. Goes to `ST_NOTE_REQ` on `start`.

From every state, `stop` forces the machine back to `ST_IDLE`.

Top module: `tune_player`

## Requirements
- R1: In the idle state, a `start` pulse with `song_sel` from 1 to 31 begins a tune: the cycle after the pulse has `mem_rd`=1 and `mem_addr`=`song_sel`, and `busy` is high. The low ADDR_W bits of that table word give the address of the first note. With `song_sel`=0, `start` is ignored and `busy` stays low.
- R2: Notes are read at consecutive addresses, starting at the table pointer, one read per note. The note word fields are: [21:16] pitch, [15:13] beat, [12:9] tempo, [8] tremolo, [7] triple, [6:5] percussion, [4] last note. Each note occupies one read cycle and one capture cycle, and its play cycles follow.
- R3: A note plays for units(beat) × (tempo+1) × TEMPO_STEP cycles. Beat codes 0 to 5 give units of 1, 2, 3, 4, 6 and 8. Codes 6 and 7 count as 8.
- R4: `tone_a` is a square wave that starts low at the first play cycle, with a half period h in cycles. To get h, clamp the pitch code p to at most 40, then take s=40−p, octave o=s/12 and remainder r=s%12. Then h = ((round(1024·2^(r/12)) × TONE_SCALE) >> 10) << o.
- R5: With the triple bit set, the half period is h/3, floored, and at least 1.
- R6: With the tremolo bit set, both tone outputs are held low during play cycles whose elapsed count n (0 at the first play cycle) has bit TREM_BIT set.
- R7: With percussion 00, `tone_b` is a square wave with half period 2h that rises at elapsed count h.
- R8: With percussion 01, 10 or 11, `tone_b` is bit 0 of an 8-bit shift register. The register is seeded with A5h at note load. It shifts left, taking in bit7^bit5^bit4^bit3, at play cycles where n mod P = 0, with P being 1, 2 or 4 respectively. The new value shows from the next cycle.
- R9: In tune mode (`per_note_mode`=0 at start), `busy` stays high from the first table read until the last note ends. A `start` pulse while busy is ignored.
- R10: In note mode, `busy` falls after every note and the block holds, with silent outputs. A `start` pulse resumes with the next note, and `song_sel` is ignored at that point. After the last note, the block returns to idle.
- R11: `irq` is a one-cycle pulse, issued in the first cycle after each completion that lowers `busy`.
- R12: `stop` takes priority in every state. In the next cycle, `busy`, `irq`, `tone_a` and `tone_b` are all low, and the block is idle.
- R13: After reset, and whenever no note is playing, `tone_a`, `tone_b`, `busy`, `irq` and `mem_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tune, or resume in note mode |
| stop | input | 1 | Abort playback |
| song_sel | input | 5 | Tune number, 0 meaning none |
| per_note_mode | input | 1 | 1: busy per note; 0: busy per tune |
| mem_rd | output | 1 | Note memory read strobe |
| mem_addr | output | ADDR_W | Note memory read address |
| mem_rdata | input | 22 | Word read, valid one cycle after the strobe |
| busy | output | 1 | Playback in progress |
| irq | output | 1 | Completion pulse |
| tone_a | output | 1 | Main tone |
| tone_b | output | 1 | Octave-below tone or percussion noise |

## Verification
A wrong state, pointer or beat count shows within one cycle as a mismatch on `busy`, `mem_rd` or `mem_addr`, because every fetch and every note boundary appears at the ports. A wrong divider, elapsed count or shift-register value shows on `tone_a` or `tone_b` within one half period, or within one shift step. The reference model tracks each of these cycle by cycle, so a fault is located to the exact cycle and note in which it first appears.

// File: rtl/tune_pkg.sv
package tune_pkg;

    localparam int NOTE_W = 22;
    localparam int SONG_W = 5;
    localparam int PITCH_TOP = 40;

    typedef struct packed {
        logic [5:0] pitch;
        logic [2:0] beat;
        logic [3:0] tempo;
        logic       trem;
        logic       triple;
        logic [1:0] perc;
        logic       last;
        logic [3:0] spare;
    } note_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TBL_REQ,
        ST_TBL_CAP,
        ST_NOTE_REQ,
        ST_NOTE_CAP,
        ST_PLAY,
        ST_WAIT
    } seq_state_t;

    function automatic int beat_units(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 3;
            3'd3:    return 4;
            3'd4:    return 6;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/tune_seq_fsm.sv
module tune_seq_fsm
    import tune_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int TEMPO_STEP = 8,
    parameter int DUR_W      = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [SONG_W-1:0] song_sel,
    input  logic              per_note_mode,
    input  logic [NOTE_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              note_load,
    output logic              playing,
    output logic              idle,
    output logic              busy,
    output logic              irq,
    output logic              trem,
    output logic [1:0]        perc,
    output logic [DUR_W-1:0]  age
);

    seq_state_t st_q, st_d;

    logic [SONG_W-1:0] song_q;
    logic              mode_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [DUR_W-1:0]  dur_q;
    logic [DUR_W-1:0]  age_q;
    logic              trem_q;
    logic [1:0]        perc_q;
    logic              last_q;
    logic              irq_q;

    note_t            rd;
    logic [DUR_W-1:0] dur_new;
    logic             note_end;
    logic             accept;

    assign rd       = note_t'(mem_rdata);
    assign dur_new  = DUR_W'(beat_units(rd.beat) * (int'(rd.tempo) + 1) * TEMPO_STEP);
    assign note_end = (st_q == ST_PLAY) && (age_q == dur_q - 1'b1);
    assign accept   = start && (song_sel != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        if (stop) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:     if (accept) st_d = ST_TBL_REQ;
                ST_TBL_REQ:  st_d = ST_TBL_CAP;
                ST_TBL_CAP:  st_d = ST_NOTE_REQ;
                ST_NOTE_REQ: st_d = ST_NOTE_CAP;
                ST_NOTE_CAP: st_d = ST_PLAY;
                ST_PLAY: begin
                    if (note_end) begin
                        if (last_q)      st_d = ST_IDLE;
                        else if (mode_q) st_d = ST_WAIT;
                        else             st_d = ST_NOTE_REQ;
                    end
                end
                ST_WAIT:     if (start) st_d = ST_NOTE_REQ;
                default:     st_d = ST_IDLE;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        mem_rd    = 1'b0;
        mem_addr  = '0;
        note_load = 1'b0;
        playing   = 1'b0;
        idle      = 1'b0;
        busy      = 1'b1;
        unique case (st_q)
            ST_IDLE: begin
                idle = 1'b1;
                busy = 1'b0;
            end
            ST_TBL_REQ: begin
                mem_rd   = 1'b1;
                mem_addr = ADDR_W'(song_q);
            end
            ST_TBL_CAP: ;
            ST_NOTE_REQ: begin
                mem_rd   = 1'b1;
                mem_addr = ptr_q;
            end
            ST_NOTE_CAP: note_load = 1'b1;
            ST_PLAY:     playing = 1'b1;
            ST_WAIT:     busy = 1'b0;
            default:     busy = 1'b0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            song_q <= '0;
            mode_q <= 1'b0;
            ptr_q  <= '0;
            dur_q  <= '0;
            age_q  <= '0;
            trem_q <= 1'b0;
            perc_q <= 2'b00;
            last_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (!stop) begin
                case (st_q)
                    ST_IDLE: begin
                        if (accept) begin
                            song_q <= song_sel;
                            mode_q <= per_note_mode;
                        end
                    end
                    ST_TBL_CAP: ptr_q <= mem_rdata[ADDR_W-1:0];
                    ST_NOTE_CAP: begin
                        ptr_q  <= ptr_q + 1'b1;
                        dur_q  <= dur_new;
                        age_q  <= '0;
                        trem_q <= rd.trem;
                        perc_q <= rd.perc;
                        last_q <= rd.last;
                    end
                    ST_PLAY: begin
                        if (note_end) irq_q <= last_q | mode_q;
                        else          age_q <= age_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign irq  = irq_q;
    assign trem = trem_q;
    assign perc = perc_q;
    assign age  = age_q;

endmodule

// File: rtl/tune_pitch.sv
module tune_pitch
    import tune_pkg::*;
#(
    parameter int HALF_W     = 12,
    parameter int TONE_SCALE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       run,
    input  logic [5:0] pitch_code,
    input  logic       x3,
    output logic       ph_a,
    output logic       ph_b
);

    function automatic int ratio_q10(input int r);
        case (r)
            0:       return 1024;
            1:       return 1085;
            2:       return 1149;
            3:       return 1218;
            4:       return 1290;
            5:       return 1367;
            6:       return 1448;
            7:       return 1534;
            8:       return 1625;
            9:       return 1722;
            10:      return 1825;
            default: return 1933;
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] half_of(input logic [5:0] code, input logic tripled);
        int p, s, oct, h;
        p   = (int'(code) > PITCH_TOP) ? PITCH_TOP : int'(code);
        s   = PITCH_TOP - p;
        oct = s / 12;
        h   = ((ratio_q10(s % 12) * TONE_SCALE) >>> 10) <<< oct;
        if (tripled) h = h / 3;
        if (h < 1)   h = 1;
        return HALF_W'(h);
    endfunction

    logic [HALF_W-1:0] half_q;
    logic [HALF_W-1:0] cnt_q;
    logic              a_q, b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= HALF_W'(1);
            cnt_q  <= '0;
            a_q    <= 1'b0;
            b_q    <= 1'b0;
        end else if (load) begin
            half_q <= half_of(pitch_code, x3);
            cnt_q  <= '0;
            a_q    <= 1'b0;
            b_q    <= 1'b0;
        end else if (run) begin
            if (cnt_q == half_q - 1'b1) begin
                cnt_q <= '0;
                a_q   <= ~a_q;
                if (!a_q) b_q <= ~b_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ph_a = a_q;
    assign ph_b = b_q;

endmodule

// File: rtl/tune_noise.sv
module tune_noise #(
    parameter logic [7:0] SEED = 8'hA5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic shift_en,
    output logic bit_o
);

    logic [7:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr_q <= SEED;
        else if (load)     sr_q <= SEED;
        else if (shift_en) sr_q <= {sr_q[6:0], sr_q[7] ^ sr_q[5] ^ sr_q[4] ^ sr_q[3]};
    end

    assign bit_o = sr_q[0];

endmodule

// File: rtl/tune_player.sv
module tune_player
    import tune_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int TEMPO_STEP = 8,
    parameter int TONE_SCALE = 16,
    parameter int HALF_W     = 12,
    parameter int TREM_BIT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [4:0]        song_sel,
    input  logic              per_note_mode,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [21:0]       mem_rdata,
    output logic              busy,
    output logic              irq,
    output logic              tone_a,
    output logic              tone_b
);

    localparam int DUR_MAX = 8 * 16 * TEMPO_STEP;
    localparam int DUR_W   = $clog2(DUR_MAX + 1);

    logic             note_load, playing, fsm_idle;
    logic             trem;
    logic [1:0]       perc;
    logic [DUR_W-1:0] age;
    logic             ph_a, ph_b, nz;
    logic             gate_off, shift_en;
    logic [1:0]       step_mask;
    note_t            nrd;
    logic             unused_spare;

    assign nrd          = note_t'(mem_rdata);
    assign unused_spare = ^nrd.spare;

    tune_seq_fsm #(
        .ADDR_W    (ADDR_W),
        .TEMPO_STEP(TEMPO_STEP),
        .DUR_W     (DUR_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .stop         (stop),
        .song_sel     (song_sel),
        .per_note_mode(per_note_mode),
        .mem_rdata    (mem_rdata),
        .mem_rd       (mem_rd),
        .mem_addr     (mem_addr),
        .note_load    (note_load),
        .playing      (playing),
        .idle         (fsm_idle),
        .busy         (busy),
        .irq          (irq),
        .trem         (trem),
        .perc         (perc),
        .age          (age)
    );

    tune_pitch #(
        .HALF_W    (HALF_W),
        .TONE_SCALE(TONE_SCALE)
    ) u_pitch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (note_load),
        .run       (playing),
        .pitch_code(nrd.pitch),
        .x3        (nrd.triple),
        .ph_a      (ph_a),
        .ph_b      (ph_b)
    );

    always_comb begin
        unique case (perc)
            2'd2:    step_mask = 2'b01;
            2'd3:    step_mask = 2'b11;
            default: step_mask = 2'b00;
        endcase
    end

    assign shift_en = playing && (perc != 2'd0) && ((age[1:0] & step_mask) == 2'b00);

    tune_noise u_noise (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (note_load),
        .shift_en(shift_en),
        .bit_o   (nz)
    );

    assign gate_off = trem & age[TREM_BIT];
    assign tone_a   = playing & ~gate_off & ph_a;
    assign tone_b   = playing & ~gate_off & ((perc != 2'd0) ? nz : ph_b);

endmodule

// File: rtl/tune_player_chk.sv
module tune_player_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              stop,
    input logic [4:0]        song_sel,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              irq,
    input logic              tone_a,
    input logic              tone_b,
    input logic              fsm_idle
);

    // R1: an accepted start reads the table entry of that tune next cycle
    a_r1_table_read: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_idle && start && !stop && song_sel != 5'd0)
        |=> (mem_rd && busy && mem_addr == {{(ADDR_W-5){1'b0}}, $past(song_sel)}));

    // R1: tune number zero leaves the block idle
    a_r1_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_idle && start && song_sel == 5'd0) |=> !busy);

    // R11: interrupt lasts a single cycle
    a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R11: interrupt only follows a busy cycle and comes with busy low
    a_r11_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));

    // R12: stop quiets everything in the next cycle
    a_r12_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!busy && !irq && !tone_a && !tone_b && fsm_idle));

    // R13: no tone without playback
    a_r13_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tone_a && !tone_b));

endmodule

bind tune_player tune_player_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .stop    (stop),
    .song_sel(song_sel),
    .mem_rd  (mem_rd),
    .mem_addr(mem_addr),
    .busy    (busy),
    .irq     (irq),
    .tone_a  (tone_a),
    .tone_b  (tone_b),
    .fsm_idle(fsm_idle)
);

// File: tb/sim_tune_player.sv
`timescale 1ns/1ps
module sim_tune_player;

    localparam int ADDR_W     = 10;
    localparam int TEMPO_STEP = 8;
    localparam int TONE_SCALE = 16;
    localparam int TREM_BIT   = 2;
    localparam int LIMIT      = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              stop = 1'b0;
    logic [4:0]        song_sel = '0;
    logic              per_note_mode = 1'b0;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [21:0]       mem_rdata = '0;
    logic              busy, irq, tone_a, tone_b;

    logic [21:0] mem [1024];

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;
    string cur_req = "R13";

    // reference model state
    int m_st = 0, m_song = 0, m_mode = 0, m_ptr = 0, m_dur = 0, m_age = 0;
    int m_pitch = 0, m_x3 = 0, m_trem = 0, m_perc = 0, m_last = 0, m_lfsr = 8'hA5, m_irq = 0;

    always #4 clk = ~clk;

    tune_player #(
        .ADDR_W    (ADDR_W),
        .TEMPO_STEP(TEMPO_STEP),
        .TONE_SCALE(TONE_SCALE),
        .TREM_BIT  (TREM_BIT)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .stop         (stop),
        .song_sel     (song_sel),
        .per_note_mode(per_note_mode),
        .mem_rd       (mem_rd),
        .mem_addr     (mem_addr),
        .mem_rdata    (mem_rdata),
        .busy         (busy),
        .irq          (irq),
        .tone_a       (tone_a),
        .tone_b       (tone_b)
    );

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    function automatic int note_w(int p, int b, int t, int tr, int x3, int pc, int e);
        return (p << 16) | (b << 13) | (t << 9) | (tr << 8) | (x3 << 7) | (pc << 5) | (e << 4);
    endfunction

    function automatic int units_of(int b);
        int u[6] = '{1, 2, 3, 4, 6, 8};
        return (b > 5) ? 8 : u[b];
    endfunction

    function automatic int half_of(int p, int x3);
        int pc, s, k, h;
        pc = (p > 40) ? 40 : p;
        s  = 40 - pc;
        k  = $rtoi(1024.0 * (2.0 ** ((s % 12) / 12.0)) + 0.5);
        h  = ((k * TONE_SCALE) >> 10) << (s / 12);
        if (x3 != 0) h = h / 3;
        if (h < 1) h = 1;
        return h;
    endfunction

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_irq = 0; m_age = 0;
        end else begin
            m_irq = 0;
            if (stop) m_st = 0;
            else if (m_st == 0) begin
                if (start && song_sel != 0) begin m_song = song_sel; m_mode = per_note_mode; m_st = 1; end
            end else if (m_st == 1) m_st = 2;
            else if (m_st == 2) begin m_ptr = mem[m_song] & 1023; m_st = 3; end
            else if (m_st == 3) m_st = 4;
            else if (m_st == 4) begin
                int w;
                w = mem[m_ptr];
                m_pitch = (w >> 16) & 63;
                m_dur   = units_of((w >> 13) & 7) * (((w >> 9) & 15) + 1) * TEMPO_STEP;
                m_trem  = (w >> 8) & 1;
                m_x3    = (w >> 7) & 1;
                m_perc  = (w >> 5) & 3;
                m_last  = (w >> 4) & 1;
                m_ptr   = (m_ptr + 1) & 1023;
                m_age   = 0;
                m_lfsr  = 8'hA5;
                m_st    = 5;
            end else if (m_st == 5) begin
                if (m_perc != 0 && (m_age % (1 << (m_perc - 1))) == 0)
                    m_lfsr = ((m_lfsr << 1) | (((m_lfsr >> 7) ^ (m_lfsr >> 5) ^ (m_lfsr >> 4) ^ (m_lfsr >> 3)) & 1)) & 255;
                if (m_age == m_dur - 1) begin
                    m_irq = (m_last != 0 || m_mode != 0) ? 1 : 0;
                    m_st  = (m_last != 0) ? 0 : ((m_mode != 0) ? 6 : 3);
                end else m_age++;
            end else if (m_st == 6) begin
                if (start) m_st = 3;
            end
        end
        if (cyc > LIMIT && !done) begin
            n_tests++; n_fail++;
            $display("FAIL R13 watchdog: actual %0d cycles, expected under %0d", cyc, LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e_busy, e_rd, e_addr, pl, gate, h, e_a, e_b, a_addr;
            e_busy = (m_st != 0 && m_st != 6);
            e_rd   = (m_st == 1 || m_st == 3);
            e_addr = (m_st == 1) ? m_song : m_ptr;
            pl     = (m_st == 5);
            gate   = m_trem & ((m_age >> TREM_BIT) & 1);
            h      = half_of(m_pitch, m_x3);
            e_a    = pl && !gate && ((m_age / h) % 2 == 1);
            e_b    = pl && !gate && ((m_perc != 0) ? (m_lfsr & 1) : ((m_age + h) / (2 * h)) % 2);
            a_addr = e_rd ? int'(mem_addr) : e_addr;
            n_tests++;
            if (busy !== e_busy[0] || irq !== m_irq[0] || mem_rd !== e_rd[0] ||
                a_addr != e_addr || tone_a !== e_a[0] || tone_b !== e_b[0]) begin
                n_fail++;
                $display("FAIL %s cycle %0d: actual busy=%b irq=%b rd=%b addr=%0d a=%b b=%b expected busy=%0d irq=%0d rd=%0d addr=%0d a=%0d b=%0d",
                         cur_req, cyc, busy, irq, mem_rd, a_addr, tone_a, tone_b,
                         e_busy, m_irq, e_rd, e_addr, e_a, e_b);
            end
        end
    end

    task automatic check(string req, int act, int exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_tune(int s, bit pn, int poke, int exp_busy, int exp_irq, string req);
        int nb = 0, ni = 0, it = 0;
        @(negedge clk);
        song_sel = 5'(s); per_note_mode = pn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            nb += int'(busy);
            ni += int'(irq);
            if (m_st == 0) break;
            start = 1'b0;
            if (m_st == 6) begin song_sel = 5'd4; start = 1'b1; end
            if (it == poke) begin song_sel = 5'd2; start = 1'b1; end
            it++;
            @(negedge clk);
        end
        start = 1'b0;
        check(req, nb, exp_busy, "busy cycle count");
        check("R11", ni, exp_irq, "irq pulse count");
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        mem[1] = 22'd40; mem[2] = 22'd60; mem[3] = 22'd80; mem[4] = 22'd100;
        // tune 1: pitch range ends, triple, long beat
        mem[40] = 22'(note_w(40, 0, 0, 0, 0, 0, 0));
        mem[41] = 22'(note_w(0, 1, 1, 0, 0, 0, 0));
        mem[42] = 22'(note_w(12, 2, 0, 0, 1, 0, 0));
        mem[43] = 22'(note_w(27, 5, 2, 0, 0, 0, 1));
        // tune 2: tremolo, clamp, percussion kinds, beat code 7
        mem[60] = 22'(note_w(20, 3, 0, 1, 0, 0, 0));
        mem[61] = 22'(note_w(63, 1, 0, 0, 0, 1, 0));
        mem[62] = 22'(note_w(5, 7, 0, 1, 0, 2, 0));
        mem[63] = 22'(note_w(30, 4, 0, 0, 0, 3, 1));
        // tune 3: played in note mode
        mem[80] = 22'(note_w(33, 0, 3, 0, 0, 0, 0));
        mem[81] = 22'(note_w(8, 1, 0, 0, 0, 0, 0));
        mem[82] = 22'(note_w(40, 0, 0, 0, 0, 0, 1));
        // tune 4: long note, aborted
        mem[100] = 22'(note_w(10, 5, 15, 0, 0, 0, 1));

        repeat (3) @(negedge clk);
        cur_req = "R13";
        check("R13", int'(busy), 0, "busy after reset");
        check("R13", int'(tone_a | tone_b | irq | mem_rd), 0, "outputs after reset");
        rst_n = 1'b1;

        // R1: tune zero ignored
        cur_req = "R1";
        @(negedge clk); song_sel = 5'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", int'(busy), 0, "busy after start with tune 0");

        // R2 R3 R4 R5 R9: tune mode, start poke while busy ignored
        cur_req = "R2/R3/R4/R5/R9";
        run_tune(1, 1'b0, 50, 2 + 4 * 2 + 8 + 32 + 24 + 192, 1, "R3");

        // R6 R7 R8: tremolo and percussion
        cur_req = "R6/R7/R8/R3";
        run_tune(2, 1'b0, -1, 2 + 4 * 2 + 32 + 16 + 64 + 48, 1, "R6");

        // R10: note mode, resumes on start, tune number ignored
        cur_req = "R10/R11";
        run_tune(3, 1'b1, -1, 2 + 3 * 2 + 32 + 16 + 8, 3, "R10");
        check("R10", int'(busy), 0, "busy after last note in note mode");

        // R12: abort
        cur_req = "R12";
        @(negedge clk); song_sel = 5'd4; per_note_mode = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (60) @(negedge clk);
        check("R12", int'(busy), 1, "busy before stop");
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        check("R12", int'(busy), 0, "busy after stop");
        check("R12", int'(tone_a | tone_b | irq), 0, "outputs after stop");
        repeat (20) @(negedge clk);
        check("R12", int'(busy | irq), 0, "no late completion after stop");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule